// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block sits between a controller and the gate drivers of a single half bridge. It takes a command for the upper switch and a command for the lower switch, and it drives one gate enable for each. The two enables are never high together. Before either enable turns on, the opposite enable must have been off for a fixed number of clock cycles. That count is set by a parameter when the block is built.

The interlock only waits when it has to. If the controller already left a gap between the two commands that is as long as the dead time, the gate turns on with no extra delay. So the effective gap is the larger of the built-in dead time and the controller's gap. Turning a gate off never waits. A channel that switches while the other one stays idle follows its command after the fixed pipeline latency only. If both commands are high at the same time, both gates are forced off, and no error is reported. Because the block resolves every overlap itself, a controller can drive it with one signal and that signal's inverse.

Each command passes through a synchroniser of `SYNC_STAGES` flops. One output register follows the synchroniser. The pipeline latency is therefore `SYNC_STAGES + 1` clock cycles. The block uses one clock and a synchronous, active-high reset.

Top module: `hb_interlock`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: While `rst` is high, and in the first cycle after it falls, both gate outputs are low, whatever the command inputs are.
- R3: While both synchronised commands are high, both gate outputs are low from the next cycle onward. No error indication exists. The block only blocks the conflicting turn-on.
- R4: A gate output rises only after the opposite gate output has been low for at least `DEAD_CYC` consecutive cycles. When the two commands swap in the same cycle (command and inverse), the rising gate goes high `SYNC_STAGES + 1 + DEAD_CYC` cycles after the input change.
- R5: When the opposite command is low and the opposite gate has already been low for `DEAD_CYC` cycles or more, a gate rises `SYNC_STAGES + 1` cycles after its own command rises. No interlock delay is added.
- R6: A gate output falls `SYNC_STAGES + 1` cycles after its own command falls. No dead time is inserted on turn-off.
- R7: Suppose the controller leaves a gap of G cycles between one command falling and the other rising. The second gate then rises max(G, `DEAD_CYC`) cycles after the first gate falls. The dead time is never added on top of the controller's gap.
- R8: A pending turn-on is granted only if the gate's own command is still high when the wait ends. If the opposite gate turns on during the wait, the wait restarts from zero when that gate turns off again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 1 | Upper switch on-command (asynchronous) |
| cmd_lo | input | 1 | Lower switch on-command (asynchronous) |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |

## Verification
The hardest case to reach from the ports is a dead-time wait that is interrupted part-way. There are two ways this happens.
- **Own command withdrawn.** The command is dropped before the count finishes, so the gate must never rise.
- **Opposite side back on.** The opposite side turns on again mid-wait, so the count must restart from zero rather than resume.

The bench reaches both by timing command changes to land a few cycles after the opposite gate has fallen, well inside the dead-time window. It then watches the gates cycle by cycle. A later full swap shows that the whole `DEAD_CYC` delay applies again.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   localparam int SIDE_HI   = 0;
   localparam int SIDE_LO   = 1;
   localparam int NUM_SIDES = 2;

   // width of a counter that must hold the value n-1 (at least one bit)
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width of a counter that must hold the value n
   function automatic int run_width(input int n);
      return (n > 0) ? $clog2(n + 1) : 1;
   endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_gap_timer.sv
module hbi_gap_timer #(
   parameter int DEAD_CYC = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic opp_on,
   output logic expired
);
   import hbi_pkg::*;
   localparam int          CW    = cnt_width(DEAD_CYC);
   localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= LIMIT;
      else if (opp_on)      cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIMIT);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= LIMIT);  // R4

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      opp_on |=> (cnt == '0));  // R8
endmodule

// File: rtl/hbi_leg.sv
module hbi_leg (
   input  logic clk,
   input  logic rst,
   input  logic own_cmd,
   input  logic opp_cmd,
   input  logic opp_gate,
   input  logic wait_done,
   output logic gate
);
   logic grant;

   assign grant = own_cmd && !opp_cmd && !opp_gate && wait_done;

   always_ff @(posedge clk) begin
      if (rst) gate <= 1'b0;
      else     gate <= grant;
   end

   AST_OFF_NEXT: assert property (@(posedge clk) disable iff (rst)
      !own_cmd |=> !gate);  // R6
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
   parameter int DEAD_CYC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cmd_hi,
   input  logic cmd_lo,
   output logic gate_hi,
   output logic gate_lo
);
   import hbi_pkg::*;
   localparam int RW = run_width(DEAD_CYC);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hb_interlock: DEAD_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hb_interlock: SYNC_STAGES must be at least 2");
   end

   logic [NUM_SIDES-1:0] cmd_raw;
   logic [NUM_SIDES-1:0] cmd_s;
   logic [NUM_SIDES-1:0] gate_v;
   logic [NUM_SIDES-1:0] done_v;

   assign cmd_raw[SIDE_HI] = cmd_hi;
   assign cmd_raw[SIDE_LO] = cmd_lo;

   hbi_sync #(.WIDTH(NUM_SIDES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (cmd_raw),
      .q   (cmd_s)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int OPP = NUM_SIDES - 1 - s;

      hbi_gap_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
         .clk     (clk),
         .rst     (rst),
         .opp_on  (gate_v[OPP]),
         .expired (done_v[s])
      );

      hbi_leg u_leg (
         .clk       (clk),
         .rst       (rst),
         .own_cmd   (cmd_s[s]),
         .opp_cmd   (cmd_s[OPP]),
         .opp_gate  (gate_v[OPP]),
         .wait_done (done_v[s]),
         .gate      (gate_v[s])
      );

      // checker: consecutive cycles this gate has been low (saturating)
      logic [RW-1:0] low_run;
      always_ff @(posedge clk) begin
         if (rst)                              low_run <= RW'(DEAD_CYC);
         else if (gate_v[s])                   low_run <= '0;
         else if (low_run != RW'(DEAD_CYC))    low_run <= low_run + 1'b1;
      end
   end

   assign gate_hi = gate_v[SIDE_HI];
   assign gate_lo = gate_v[SIDE_LO];

   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi && gate_lo));  // R1

   AST_RESET_LOW: assert property (@(posedge clk)
      rst |=> (!gate_hi && !gate_lo));  // R2

   AST_OVERLAP_OFF: assert property (@(posedge clk) disable iff (rst)
      (cmd_s[SIDE_HI] && cmd_s[SIDE_LO]) |=> (!gate_hi && !gate_lo));  // R3

   AST_GAP_HI: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi) |-> (g_side[SIDE_LO].low_run >= RW'(DEAD_CYC)));  // R4

   AST_GAP_LO: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo) |-> (g_side[SIDE_HI].low_run >= RW'(DEAD_CYC)));  // R4

   AST_LONE_HI: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmd_s[SIDE_HI]) && !cmd_s[SIDE_LO] && !gate_lo &&
       g_side[SIDE_LO].low_run >= RW'(DEAD_CYC)) |=> gate_hi);  // R5

   AST_LONE_LO: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmd_s[SIDE_LO]) && !cmd_s[SIDE_HI] && !gate_hi &&
       g_side[SIDE_HI].low_run >= RW'(DEAD_CYC)) |=> gate_lo);  // R5
endmodule

// File: tb/tb_hb_interlock.sv
module tb_hb_interlock;
   localparam int CLK_PERIOD = 10;
   localparam int DT  = 6;
   localparam int SS  = 2;
   localparam int LAT = SS + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd_hi = 1'b0;
   logic cmd_lo = 1'b0;
   logic gate_hi, gate_lo;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_interlock #(.DEAD_CYC(DT), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic h, input logic l);
      cmd_hi = h;
      cmd_lo = l;
   endtask

   task automatic chk(input logic [1:0] exp, input string tag);
      checks++;
      if ({gate_hi, gate_lo} !== exp) begin
         errors++;
         $display("FAIL %s: {gate_hi,gate_lo} actual=%b expected=%b", tag, {gate_hi, gate_lo}, exp);
      end
   endtask

   task automatic t_reset();
      cyc(2);
      drive(1, 0);
      cyc(LAT + 2);
      chk(2'b00, "R2 outputs low in reset with cmd_hi high");
      drive(0, 1);
      cyc(LAT + 2);
      chk(2'b00, "R2 outputs low in reset with cmd_lo high");
      drive(0, 0);
      cyc(2);
      rst = 1'b0;
      cyc(1);
      chk(2'b00, "R2 outputs low after reset release");
   endtask

   task automatic t_lone();
      drive(1, 0);
      cyc(LAT - 1); chk(2'b00, "R5 lone hi before latency");
      cyc(1);       chk(2'b10, "R5 lone hi on after latency only");
      drive(0, 0);
      cyc(LAT - 1); chk(2'b10, "R6 hi still on before latency");
      cyc(1);       chk(2'b00, "R6 hi off after latency");
      cyc(DT + 2);
      drive(0, 1);
      cyc(LAT);     chk(2'b01, "R5 lone lo on after latency only");
      drive(0, 0);
      cyc(LAT);     chk(2'b00, "R6 lo off after latency");
      cyc(DT + 2);
   endtask

   task automatic t_swap();
      drive(1, 0);
      cyc(LAT + DT + 2);
      chk(2'b10, "R5 hi on before swap");
      drive(0, 1);
      cyc(LAT - 1);  chk(2'b10, "R6 hi on before turn-off latency");
      cyc(1);        chk(2'b00, "R6 hi off, no dead time on turn-off");
      cyc(DT - 1);   chk(2'b00, "R4 lo held during dead time");
      cyc(1);        chk(2'b01, "R4 lo on after latency plus dead time");
      drive(1, 0);
      cyc(LAT);      chk(2'b00, "R6 lo off on swap back");
      cyc(DT - 1);   chk(2'b00, "R4 hi held during dead time");
      cyc(1);        chk(2'b10, "R4 hi on after latency plus dead time");
   endtask

   task automatic t_gap_long();
      // precondition: gate_hi on
      drive(0, 0);
      cyc(DT + 3);
      drive(0, 1);
      cyc(LAT - 1);  chk(2'b00, "R7 long gap, lo not early");
      cyc(1);        chk(2'b01, "R7 long gap, no added dead time");
   endtask

   task automatic t_gap_short();
      // precondition: gate_lo on
      drive(0, 0);
      cyc(2);
      drive(1, 0);
      cyc(LAT + DT - 3); chk(2'b00, "R7 short gap, hi waits for dead time");
      cyc(1);            chk(2'b10, "R7 short gap, hi on at dead time");
   endtask

   task automatic t_overlap();
      // precondition: gate_hi on
      drive(1, 1);
      cyc(LAT); chk(2'b00, "R3 both commands high forces both off");
      for (int i = 0; i < DT + 4; i++) begin
         cyc(1);
         chk(2'b00, "R3 both stay off during overlap");
      end
      drive(0, 1);
      cyc(LAT - 1); chk(2'b00, "R3 still blocked until overlap clears");
      cyc(1);       chk(2'b01, "R3 lo on once overlap clears");
   endtask

   task automatic t_abort();
      // precondition: gate_lo on
      drive(1, 0);
      cyc(LAT + 1);
      chk(2'b00, "R8 lo off, hi waiting");
      drive(0, 0);
      for (int i = 0; i < 2 * DT + LAT; i++) begin
         cyc(1);
         chk(2'b00, "R8 withdrawn command never granted");
      end
   endtask

   task automatic t_restart();
      drive(1, 0);
      cyc(LAT + 1);
      chk(2'b10, "R8 hi on before restart scenario");
      drive(0, 1);
      cyc(LAT + 2);
      chk(2'b00, "R8 lo waiting mid dead time");
      drive(1, 0);
      cyc(LAT - 1); chk(2'b00, "R8 hi not before latency");
      cyc(1);       chk(2'b10, "R8 hi back on, lo never granted");
      drive(0, 1);
      cyc(LAT);     chk(2'b00, "R8 hi off again");
      cyc(DT - 1);  chk(2'b00, "R8 lo wait restarted from zero");
      cyc(1);       chk(2'b01, "R8 lo on after full dead time");
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         checks++;
         if (gate_hi && gate_lo) begin
            errors++;
            $display("FAIL R1: both gates high actual=11 expected=not 11");
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_lone();
      t_swap();
      t_gap_long();
      t_gap_short();
      t_overlap();
      t_abort();
      t_restart();
      cyc(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule